// File: doc/BRIEF.md
# I2C Bus Unjam Sequencer

This master-side helper frees a slave that was left holding SDA low after an interrupted or failed transfer. It runs just before the normal command master issues a read or write. A single-cycle `go_i` pulse starts it. The sequencer then works both bus lines through nine identical groups. Each group is a start condition followed by one clocked data bit of value 1.

Both lines are open-drain. Each output only says whether to pull its line low. SDA is never driven high: a 1 is formed by letting go of the line so the external pull-up can raise it, which avoids a fight with a slave that still drives it low.

Each SCL phase lasts a programmable number of system clocks, so the configured SCL rate is never exceeded. During the high phase of every data bit, a synchronized copy of SDA is sampled. A sticky flag then reports whether the slave let go of the line at least once. When the ninth group finishes, a one-cycle done pulse is raised and both lines are left released, ready for the command master.

Top module: `i2c_bus_unjam`

## Requirements
- R1: Out of reset, `busy_o`, `done_o`, `sda_seen_o`, `scl_pull_o` and `sda_pull_o` are all 0. Whenever `busy_o` is 0, both pull outputs are 0.
- R2: When `go_i` is 1 at a clock edge while idle, `busy_o` is 1 from that edge on. When `go_i` is 1 while busy, it has no effect on any output.
- R3: Each group has seven quarter periods, numbered q0 to q6. The pair (`scl_pull_o`, `sda_pull_o`) takes these values in order: q0 (0,0), q1 (0,1), q2 (1,1), q3 (1,0), q4 (0,0), q5 (0,0), q6 (1,0).
- R4: A sequence has exactly nine groups, so `busy_o` stays 1 for exactly 63·(D+1) cycles.
- R5: Every quarter period lasts D+1 clock cycles, where D is `quarter_div_i` sampled at the accepting edge. Later changes to `quarter_div_i` do not affect the running sequence.
- R6: SDA is only ever pulled low or released. It is never released while SCL is released and SDA was pulled in the previous cycle, so no stop condition is ever formed.
- R7: `done_o` is a one-cycle pulse in the first cycle after `busy_o` falls, and both lines are released at that point.
- R8: `sda_i` passes through a two-stage synchronizer and is sampled on the last cycle of q5 in each group. `sda_seen_o` becomes 1 if any sample is 1, stays set, and is cleared when a new sequence is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Single-cycle request to start the sequence |
| quarter_div_i | input | DIV_W | Quarter-period length minus one, in clock cycles |
| sda_i | input | 1 | Level observed on the SDA wire (asynchronous) |
| scl_pull_o | output | 1 | 1 = pull SCL low, 0 = release SCL |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release SDA |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of the sequence |
| sda_seen_o | output | 1 | Sticky: SDA was seen high during a data bit |

## Verification
Sequences run with several divisors, including the minimum of zero, so that the quarter-period length is separated from the group and step order. The SDA level is varied between runs: held low throughout, held high throughout, released only in the first group, and released only in the last group. These patterns show that the flag samples every group, stays set once set, and clears on the next start. Start pulses and divisor changes applied in the middle of a run show that both are ignored once the sequence is busy.

// File: rtl/i2c_bus_unjam.sv
module i2c_bus_unjam #(
  parameter int DIV_W  = 8,
  parameter int GROUPS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [DIV_W-1:0] quarter_div_i,
  input  logic             sda_i,
  output logic             scl_pull_o,
  output logic             sda_pull_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             sda_seen_o
);
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam logic [2:0] LAST_STEP = 3'd6;
  localparam logic [2:0] SAMPLE_STEP = 3'd5;
  localparam logic [GW-1:0] LAST_GRP = GW'(GROUPS - 1);

  logic             busy_q, done_q, seen_q, sync1_q, sync2_q;
  logic [2:0]       step_q;
  logic [GW-1:0]    grp_q;
  logic [DIV_W-1:0] qcnt_q, div_q;

  wire q_end = (qcnt_q == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= sda_i;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      seen_q <= 1'b0;
      step_q <= '0;
      grp_q  <= '0;
      qcnt_q <= '0;
      div_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (go_i) begin
          busy_q <= 1'b1;
          seen_q <= 1'b0;
          step_q <= '0;
          grp_q  <= '0;
          qcnt_q <= '0;
          div_q  <= quarter_div_i;
        end
      end else begin
        if (q_end && step_q == SAMPLE_STEP && sync2_q)
          seen_q <= 1'b1;
        if (!q_end) begin
          qcnt_q <= qcnt_q + 1'b1;
        end else begin
          qcnt_q <= '0;
          if (step_q != LAST_STEP) begin
            step_q <= step_q + 3'd1;
          end else begin
            step_q <= '0;
            if (grp_q == LAST_GRP) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              grp_q <= grp_q + 1'b1;
            end
          end
        end
      end
    end
  end

  assign scl_pull_o = busy_q && (step_q == 3'd2 || step_q == 3'd3 || step_q == 3'd6);
  assign sda_pull_o = busy_q && (step_q == 3'd1 || step_q == 3'd2);
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign sda_seen_o = seen_q;
endmodule

module i2c_bus_unjam_chk (
  input logic clk,
  input logic rst_n,
  input logic go_i,
  input logic scl_pull_o,
  input logic sda_pull_o,
  input logic busy_o,
  input logic done_o,
  input logic sda_seen_o
);
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_pull_o && !sda_pull_o));
  p_go_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && go_i) |=> busy_o);
  p_start_scl_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_pull_o);
  p_no_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull_o && sda_pull_o) |=> !(!scl_pull_o && !sda_pull_o));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  p_seen_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && go_i) |=> !sda_seen_o);
endmodule

bind i2c_bus_unjam i2c_bus_unjam_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go_i(go_i), .scl_pull_o(scl_pull_o),
  .sda_pull_o(sda_pull_o), .busy_o(busy_o), .done_o(done_o), .sda_seen_o(sda_seen_o)
);

// File: tb/i2c_bus_unjam_test.sv
module i2c_bus_unjam_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       go_i = 0;
  logic [7:0] quarter_div_i = 0;
  logic       sda_i = 0;
  logic       scl_pull_o, sda_pull_o, busy_o, done_o, sda_seen_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // reference model state
  bit  mbusy = 0, mdone = 0;
  int  k = 0, mq = 1;
  bit [8:0] mask = '0;

  i2c_bus_unjam uut (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .quarter_div_i(quarter_div_i),
    .sda_i(sda_i), .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o),
    .busy_o(busy_o), .done_o(done_o), .sda_seen_o(sda_seen_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mbusy = 0; mdone = 0; k = 0;
    end else begin
      mdone = 0;
      if (mbusy) begin
        k++;
        if (k == 63 * mq) begin mbusy = 0; mdone = 1; end
      end else if (go_i) begin
        mbusy = 1; k = 0; mq = int'(quarter_div_i) + 1;
      end
    end
  end

  // per-cycle comparison and SDA stimulus
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
    if (rst_n) begin
      int st;
      bit escl, esda;
      st = mbusy ? (k / mq) % 7 : 0;
      escl = mbusy && (st == 2 || st == 3 || st == 6);
      esda = mbusy && (st == 1 || st == 2);
      chk(busy_o == mbusy, "R2/R4 busy", busy_o, mbusy);
      chk(scl_pull_o == escl, "R3/R5 scl_pull", scl_pull_o, escl);
      chk(sda_pull_o == esda, "R3/R6 sda_pull", sda_pull_o, esda);
      chk(done_o == mdone, "R7 done", done_o, mdone);
      sda_i = mbusy ? mask[k / (7 * mq)] : 1'b0;
    end
  end

  task automatic run(input int div, input bit [8:0] m, input bit disturb);
    mask = m;
    @(negedge clk);
    quarter_div_i = 8'(div);
    go_i = 1;
    @(negedge clk);
    go_i = 0;
    chk(busy_o == 1, "R2 busy after go", busy_o, 1);
    chk(sda_seen_o == 0, "R8 flag cleared at start", sda_seen_o, 0);
    if (disturb) begin
      repeat (20) @(negedge clk);
      go_i = 1;               // R2: ignored while busy
      quarter_div_i = 8'(div + 5); // R5: ignored mid-run
      @(negedge clk);
      go_i = 0;
    end
    while (!mdone) @(negedge clk);
    chk(sda_seen_o == (|m), "R8 flag at done", sda_seen_o, int'(|m));
    chk(!scl_pull_o && !sda_pull_o, "R7 lines released at done", {scl_pull_o, sda_pull_o}, 0);
    repeat (3) @(negedge clk);
    chk(sda_seen_o == (|m), "R8 flag sticky after done", sda_seen_o, int'(|m));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !sda_seen_o && !scl_pull_o && !sda_pull_o,
        "R1 reset state", {busy_o, done_o, sda_seen_o, scl_pull_o, sda_pull_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run(0, 9'h000, 0);        // R4 min divisor, SDA stuck low
    run(3, 9'h1FF, 0);        // R5 SDA high throughout
    run(2, 9'h100, 0);        // R8 released in last group only
    run(1, 9'h001, 1);        // R8 first group only, R2/R5 disturbances
    run(1, 9'h000, 0);        // R8 flag clears after a set run
    finish_run();
  end
endmodule